// File: doc/BRIEF.md
# Clock-Modulation Duty-Cycle Gate

This block lowers average core throughput without touching the clock frequency. It does so by forcing a programmable number of cycles in every eight-cycle frame to be idle. A free-running frame counter splits time into frames of eight cycles. In each frame the first N cycles let the core's clock-enable pass through, and the remaining 8-N cycles force it low. Anything that counts raw clock cycles, such as a timestamp, keeps counting at the full rate, because the clock itself never stops.

Two sources can ask for modulation. The first is a software on-demand setting, made of an enable bit and a 3-bit level code. The second is a thermal-monitor request, which carries a fixed level set by a parameter. A configurable minimum active level stops any request from starving the core below a floor. When both sources are active, the stricter of the two wins, meaning the one with fewer active cycles. The level in force changes only at a frame boundary.

The block has three outputs. The gated enable goes to the core. A forced-idle flag tells a utilization monitor which idle cycles were imposed rather than requested by the core. A status bit reports that modulation is in force.

Top module: `clkmod_gate`

## Requirements
- R1: While reset is held, and after release with no request, `core_en_o` equals `core_en_i`, `idle_force_o` is 0 and `mod_active_o` is 0.
- R2: With `sw_en_i`=1 and `sw_level_i`=n, where n is from 1 to 7 and at least the floor, each frame has n active cycles followed by 8-n forced-idle cycles. The frame phase is 0 in the first cycle after reset release and counts 0..7 repeatedly. Cycles at phase < n are active, and cycles at phase >= n are idle.
- R3: Level code 0 is reserved. If the code is 0, or if `sw_en_i` is 0, the software source requests nothing and produces no idle cycles.
- R4: A nonzero software level below `MIN_ACTIVE_CODE` is raised to `MIN_ACTIVE_CODE` active cycles per frame. The floor also applies to the thermal level.
- R5: While `thermal_req_i` is 1, the thermal source requests `THERMAL_CODE` active cycles per frame, whatever the software settings are.
- R6: When both sources request modulation, the frame uses the smaller of the two active counts.
- R7: A change of any request input takes effect only from the next phase-0 cycle. The rest of the current frame keeps the old pattern.
- R8: `core_en_o` is `core_en_i` AND NOT `idle_force_o`. `idle_force_o` marks forced-idle slots even when `core_en_i` is 0.
- R9: `mod_active_o` is 1 for every cycle of a frame that uses fewer than 8 active cycles, and 0 for every cycle of a frame that uses all 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en_i | input | 1 | Clock-enable requested by the core |
| sw_en_i | input | 1 | Software on-demand modulation enable |
| sw_level_i | input | LEVEL_W | Software level code: active cycles per frame, 0 reserved |
| thermal_req_i | input | 1 | Thermal-monitor modulation request |
| core_en_o | output | 1 | Gated clock-enable to the core |
| idle_force_o | output | 1 | High in cycles forced idle by modulation |
| mod_active_o | output | 1 | High while the frame in force is modulated |

## Verification
`core_en_o` and `idle_force_o` follow `core_en_i` in the same cycle. The frame level, however, is loaded on the clock edge that ends phase 7, so a request change shows up first in the phase-0 cycle that follows. The level is held for all eight slots of that frame, and `mod_active_o` changes at the same boundary. The bench keeps its own phase count from reset release. After each stimulus it waits for the next phase-0 cycle and then compares all eight slots against the expected count. The mid-frame test drives a change at phase 3 and checks that phases 3 to 7 still follow the old level. All sampling happens on the falling clock edge.

// File: rtl/clkmod_pkg.sv
// Package: shared widths and helpers for the clock-modulation gate.
// Assumes the frame length is a power of two set by the level field width.
package clkmod_pkg;

    // Return the smaller of two active counts (stricter request).
    function automatic logic [7:0] min_cnt(input logic [7:0] a, input logic [7:0] b);
        return (a < b) ? a : b;
    endfunction

    // Raise a count to a floor value.
    function automatic logic [7:0] floor_cnt(input logic [7:0] a, input logic [7:0] fl);
        return (a < fl) ? fl : a;
    endfunction

endpackage

// File: rtl/clkmod_frame_ctr.sv
// Module: free-running frame phase counter.
// Counts 0..FRAME-1 and wraps. Phase 0 is the first cycle after reset
// release. last_o marks the final slot of a frame.
module clkmod_frame_ctr #(
    parameter int LEVEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [LEVEL_W-1:0] phase_o,
    output logic               last_o
);
    localparam logic [LEVEL_W-1:0] LAST_PHASE = '1;

    logic [LEVEL_W-1:0] phase_q;

    // Advance the phase every cycle; wraps naturally at 2**LEVEL_W.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == LAST_PHASE);
endmodule

// File: rtl/clkmod_req_arb.sv
// Module: turns the software and thermal requests into one active count.
// A source that requests nothing yields FRAME (no idle cycles). Each
// request is raised to the floor, and the smaller count wins.
module clkmod_req_arb #(
    parameter int LEVEL_W         = 3,
    parameter int MIN_ACTIVE_CODE = 4,
    parameter int THERMAL_CODE    = 4
) (
    input  logic               sw_en_i,
    input  logic [LEVEL_W-1:0] sw_level_i,
    input  logic               thermal_req_i,
    output logic [LEVEL_W:0]   next_active_o
);
    import clkmod_pkg::*;

    localparam int CNT_W = LEVEL_W + 1;
    localparam int FRAME = 1 << LEVEL_W;
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] FLOOR_CNT = CNT_W'(MIN_ACTIVE_CODE);
    localparam logic [CNT_W-1:0] THERM_CNT = CNT_W'(THERMAL_CODE);

    logic [CNT_W-1:0] sw_raw, th_raw, sw_cnt, th_cnt;

    // Software source: reserved code 0 or clear enable means no request.
    always_comb begin
        if (sw_en_i && (sw_level_i != '0)) sw_raw = {1'b0, sw_level_i};
        else                               sw_raw = FRAME_CNT;
    end

    // Thermal source: fixed level while requested.
    always_comb begin
        th_raw = thermal_req_i ? THERM_CNT : FRAME_CNT;
    end

    // Floor stage: only built when the floor can actually bind.
    generate
        if (MIN_ACTIVE_CODE > 1) begin : g_floor
            always_comb begin
                sw_cnt = CNT_W'(floor_cnt(8'(sw_raw), 8'(FLOOR_CNT)));
                th_cnt = CNT_W'(floor_cnt(8'(th_raw), 8'(FLOOR_CNT)));
            end
        end else begin : g_nofloor
            always_comb begin
                sw_cnt = sw_raw;
                th_cnt = th_raw;
            end
        end
    endgenerate

    // Arbitration: fewer active cycles wins.
    always_comb begin
        next_active_o = CNT_W'(min_cnt(8'(sw_cnt), 8'(th_cnt)));
    end
endmodule

// File: rtl/clkmod_slot_gate.sv
// Module: holds the active count in force and gates the core enable.
// The count is loaded only on the edge that ends the last slot, so
// a frame never mixes two levels. Slots at phase >= count are idle.
module clkmod_slot_gate #(
    parameter int LEVEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               last_i,
    input  logic [LEVEL_W-1:0] phase_i,
    input  logic [LEVEL_W:0]   next_active_i,
    input  logic               core_en_i,
    output logic               core_en_o,
    output logic               idle_o,
    output logic               mod_active_o
);
    localparam int CNT_W = LEVEL_W + 1;
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(1 << LEVEL_W);

    logic [CNT_W-1:0] cur_active_q;

    // Latch the arbitrated count at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_active_q <= FRAME_CNT;
        else if (last_i) cur_active_q <= next_active_i;
    end

    // Decode the slot: idle once the active budget is spent.
    always_comb begin
        idle_o       = ({1'b0, phase_i} >= cur_active_q);
        core_en_o    = core_en_i & ~idle_o;
        mod_active_o = (cur_active_q != FRAME_CNT);
    end
endmodule

// File: rtl/clkmod_gate.sv
// Module: top of the clock-modulation duty-cycle gate.
// Forces part of each eight-slot frame idle per the stricter of the
// software and thermal requests. The clock is never stopped here; only
// the enable is masked. Parameters: level field width, floor, thermal level.
module clkmod_gate #(
    parameter int LEVEL_W         = 3,
    parameter int MIN_ACTIVE_CODE = 4,
    parameter int THERMAL_CODE    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_en_i,
    input  logic               sw_en_i,
    input  logic [LEVEL_W-1:0] sw_level_i,
    input  logic               thermal_req_i,
    output logic               core_en_o,
    output logic               idle_force_o,
    output logic               mod_active_o
);
    logic [LEVEL_W-1:0] phase;
    logic               last;
    logic [LEVEL_W:0]   next_active;

    clkmod_frame_ctr #(.LEVEL_W(LEVEL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .last_o  (last)
    );

    clkmod_req_arb #(
        .LEVEL_W         (LEVEL_W),
        .MIN_ACTIVE_CODE (MIN_ACTIVE_CODE),
        .THERMAL_CODE    (THERMAL_CODE)
    ) u_arb (
        .sw_en_i       (sw_en_i),
        .sw_level_i    (sw_level_i),
        .thermal_req_i (thermal_req_i),
        .next_active_o (next_active)
    );

    clkmod_slot_gate #(.LEVEL_W(LEVEL_W)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .last_i        (last),
        .phase_i       (phase),
        .next_active_i (next_active),
        .core_en_i     (core_en_i),
        .core_en_o     (core_en_o),
        .idle_o        (idle_force_o),
        .mod_active_o  (mod_active_o)
    );
endmodule

// File: rtl/clkmod_gate_chk.sv
// Checker: port-level properties of the clock-modulation gate.
// Keeps its own frame phase count from reset release.
module clkmod_gate_chk #(
    parameter int LEVEL_W         = 3,
    parameter int MIN_ACTIVE_CODE = 4
) (
    input logic clk,
    input logic rst_n,
    input logic core_en_i,
    input logic core_en_o,
    input logic idle_force_o,
    input logic mod_active_o
);
    logic [LEVEL_W-1:0] ph;

    // Independent phase count for the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + 1'b1;
    end

    AST_EN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        core_en_o |-> core_en_i);                                        // R8
    AST_IDLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        idle_force_o |-> !core_en_o);                                    // R8
    AST_NO_IDLE_UNMOD: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_active_o |-> !idle_force_o);                                // R9
    AST_IDLE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_force_o && (ph != '1)) |=> idle_force_o);                  // R2
    AST_FLOOR_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(ph) < MIN_ACTIVE_CODE) |-> !idle_force_o);                  // R4
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |-> $stable(mod_active_o));                           // R7
endmodule

bind clkmod_gate clkmod_gate_chk #(
    .LEVEL_W         (LEVEL_W),
    .MIN_ACTIVE_CODE (MIN_ACTIVE_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_en_i    (core_en_i),
    .core_en_o    (core_en_o),
    .idle_force_o (idle_force_o),
    .mod_active_o (mod_active_o)
);

// File: tb/clkmod_gate_tb.sv
// Directed bench for the clock-modulation gate.
module clkmod_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_MIN     = 3;
    localparam int TB_THERM   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_en_i = 1'b1;
    logic       sw_en_i = 1'b0;
    logic [2:0] sw_level_i = 3'd0;
    logic       thermal_req_i = 1'b0;
    logic       core_en_o, idle_force_o, mod_active_o;

    int n_checks = 0;
    int n_fail   = 0;
    int phase    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side frame phase, counted from reset release.
    always @(posedge clk) begin
        if (!rst_n) phase <= 0;
        else        phase <= (phase + 1) % 8;
    end

    clkmod_gate #(.LEVEL_W(3), .MIN_ACTIVE_CODE(TB_MIN), .THERMAL_CODE(TB_THERM)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_en_i(core_en_i), .sw_en_i(sw_en_i),
        .sw_level_i(sw_level_i), .thermal_req_i(thermal_req_i),
        .core_en_o(core_en_o), .idle_force_o(idle_force_o), .mod_active_o(mod_active_o)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s phase=%0d actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    function automatic int exp_active(logic en, int code, logic th);
        int s, t;
        s = (en && code != 0) ? ((code < TB_MIN) ? TB_MIN : code) : 8;
        t = th ? ((TB_THERM < TB_MIN) ? TB_MIN : TB_THERM) : 8;
        return (s < t) ? s : t;
    endfunction

    // Check one slot at the current (negedge) sample point.
    task automatic chk_slot(string req, int act_cnt);
        int exp_idle;
        exp_idle = (phase >= act_cnt) ? 1 : 0;
        chk({req, " idle"}, int'(idle_force_o), exp_idle);
        chk({req, " en"},   int'(core_en_o), int'(core_en_i) & (1 - exp_idle));
        chk({req, " mod"},  int'(mod_active_o), (act_cnt != 8) ? 1 : 0);
    endtask

    // Drive inputs, wait for the next frame start, check all 8 slots.
    task automatic run_frame(string req, logic en, int code, logic th);
        int a;
        sw_en_i = en; sw_level_i = 3'(code); thermal_req_i = th;
        a = exp_active(en, code, th);
        do @(negedge clk); while (phase != 0);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            chk_slot(req, a);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rst en", int'(core_en_o), 1);
        chk("R1 rst idle", int'(idle_force_o), 0);
        chk("R1 rst mod", int'(mod_active_o), 0);
        rst_n = 1'b1;
        run_frame("R1", 1'b0, 0, 1'b0);
    endtask

    task automatic t_sw_levels();
        run_frame("R2 code7", 1'b1, 7, 1'b0);
        run_frame("R2 code6", 1'b1, 6, 1'b0);
        run_frame("R2 code5", 1'b1, 5, 1'b0);
        run_frame("R2 code3", 1'b1, 3, 1'b0);
    endtask

    task automatic t_off();
        run_frame("R3 en0", 1'b0, 5, 1'b0);
        run_frame("R3 code0", 1'b1, 0, 1'b0);
    endtask

    task automatic t_floor();
        run_frame("R4 code1", 1'b1, 1, 1'b0);
        run_frame("R4 code2", 1'b1, 2, 1'b0);
    endtask

    task automatic t_thermal();
        run_frame("R5 th", 1'b0, 0, 1'b1);
        run_frame("R5 th sw7", 1'b1, 7, 1'b1);
    endtask

    task automatic t_both();
        run_frame("R6 sw3 th", 1'b1, 3, 1'b1);
        run_frame("R6 sw6 th", 1'b1, 6, 1'b1);
    endtask

    // Change mid-frame: remainder keeps old level, next frame uses new.
    task automatic t_midframe();
        run_frame("R7 pre", 1'b1, 7, 1'b0);
        do @(negedge clk); while (phase != 3);
        sw_level_i = 3'd4;
        for (int k = 3; k < 8; k++) begin
            if (k > 3) @(negedge clk);
            chk_slot("R7 old", 7);
        end
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            chk_slot("R7 new", 4);
        end
    endtask

    task automatic t_core_low();
        core_en_i = 1'b0;
        run_frame("R8 core0", 1'b1, 5, 1'b0);
        core_en_i = 1'b1;
        run_frame("R9 clear", 1'b0, 0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sw_levels();
        t_off();
        t_floor();
        t_thermal();
        t_both();
        t_midframe();
        t_core_low();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule